// File: doc/BRIEF.md
# External Interrupt Request Latch Controller

This block gathers external interrupt requests for a small CPU core. It watches one dedicated active-low interrupt pin and four general-purpose port pins. All five are asynchronous. Each passes through a synchroniser, and a falling edge on any of them sets one shared request latch. A static option bit can also make the dedicated pin sensitive to a sustained low level, in addition to its falling edges. The latch is gated by the CPU's global mask bit and by a local enable bit, and the result is one request line that the CPU samples at instruction boundaries.

The latch is cleared by the CPU's vector-fetch pulse, so an edge that arrives during the service routine is caught and held. That held request is offered again as soon as the global mask is cleared on return from interrupt. Software can also clear the latch with a write-one acknowledge strobe, and can read its state on a status output. A software-interrupt request passes straight to the CPU request line, and neither mask applies to it.

The block has no data stream. Every pin is a plain level control or status signal, and there is no valid/ready handshake.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge (1 then 0) on `irq_pin_n` sets the latch. `latch_status` reads 1 after the third rising clock edge that follows the pin going low, and reads 0 after only two.
- R2: A falling edge on any bit of `port_pin_n[3:0]` sets the same latch, with the same three-edge delay.
- R3: With `level_opt`=0, a rising edge or a steady level on any pin leaves the latch at 0.
- R4: `irq_req` equals `irq_pending` AND NOT `cpu_i_mask` AND `irq_enable`, for all four combinations of the two gates.
- R5: `irq_take` is 1 only in a cycle where `inst_boundary`=1 and `irq_req`=1.
- R6: A `vec_fetch` pulse clears the latch. A falling edge that arrives after that pulse sets the latch again, and the latch holds while `cpu_i_mask`=1. `irq_req` rises in the same cycle that `cpu_i_mask` falls.
- R7: If a detected falling edge and a `vec_fetch` or `ack_wr` clear fall in the same cycle, the latch ends up at 1.
- R8: An `ack_wr` pulse with no edge in the same cycle clears the latch.
- R9: With `level_opt`=1, `irq_pending` is 1 while the synchronised `irq_pin_n` is low, even after the latch has been cleared. It returns to the latch value once the pin goes high. Port pins are never level sensitive.
- R10: `cpu_int_req` is 1 whenever `swi_req` is 1, whatever the values of `cpu_i_mask` and `irq_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pin_n | input | 1 | Dedicated active-low interrupt pin, asynchronous |
| port_pin_n | input | 4 | Port pins that can raise interrupts on falling edges, asynchronous |
| level_opt | input | 1 | Static option: 0 = falling edge only, 1 = falling edge plus low level |
| cpu_i_mask | input | 1 | CPU global interrupt mask; 1 blocks external requests |
| irq_enable | input | 1 | Local enable for external interrupts |
| inst_boundary | input | 1 | High in a cycle where the CPU is at an instruction boundary |
| vec_fetch | input | 1 | Pulse in the vector-fetch cycle; clears the latch |
| ack_wr | input | 1 | Write-one acknowledge strobe; clears the latch |
| swi_req | input | 1 | Software-interrupt request, not maskable |
| latch_status | output | 1 | Current state of the request latch |
| irq_pending | output | 1 | Latch state ORed with the level-sensed low |
| irq_req | output | 1 | Pending request after both gates |
| irq_take | output | 1 | The CPU accepts the external interrupt this cycle |
| cpu_int_req | output | 1 | Combined request to the CPU (external or software) |

## Verification
Two functions can land in the same cycle: a newly detected falling edge setting the latch, and a clear from `vec_fetch` or `ack_wr`. The bench first sets the latch, then drives a new falling edge and asserts the clear exactly two rising edges later, when the detector reports the edge. It expects `latch_status` to be 1, and compares this with a clear on its own, which must give 0. The bench also sweeps all sources, both gate bits and both sensitivity options, and computes the expected gated request arithmetically.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NPORT_DEF = 4;
  localparam int unsigned SYNC_DEF  = 2;

  typedef enum logic {
    SENSE_EDGE       = 1'b0,
    SENSE_EDGE_LEVEL = 1'b1
  } sense_e;

  function automatic int unsigned src_count(input int unsigned nport);
    return nport + 1;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n,
  output logic [W-1:0] sync_n
);
  localparam int unsigned TOP = STAGES - 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pin_n[g]};
    end
    assign sync_n[g] = chain[TOP];
  end
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_n,
  output logic [W-1:0] fall,
  output logic         any_fall
);
  logic [W-1:0] prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= cur_n;
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      fall[i] = prev_n[i] & ~cur_n[i];
    end
    any_fall = |fall;
  end

  // R3: a reported edge needs a low now that was high one cycle earlier
  p_fall_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_fall |-> (cur_n != '1));
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_vec_i,
  input  logic clr_ack_i,
  output logic q
);
  logic clr_any;
  assign clr_any = clr_vec_i | clr_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_i)   q <= 1'b1;
    else if (clr_any) q <= 1'b0;
  end

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_any) |=> q);
  p_vec_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec_i && !set_i) |=> !q);
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ack_i && !set_i) |=> !q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr_any) |=> q);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NPORT  = NPORT_DEF,
  parameter int unsigned STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pin_n,
  input  logic             level_opt,
  input  logic             cpu_i_mask,
  input  logic             irq_enable,
  input  logic             inst_boundary,
  input  logic             vec_fetch,
  input  logic             ack_wr,
  input  logic             swi_req,
  output logic             latch_status,
  output logic             irq_pending,
  output logic             irq_req,
  output logic             irq_take,
  output logic             cpu_int_req
);
  localparam int unsigned NSRC    = src_count(NPORT);
  localparam int unsigned IRQ_IDX = NSRC - 1;

  logic [NSRC-1:0] raw_n, sync_n, fall;
  logic            any_fall, level_low, gate_open;
  sense_e          sense;

  assign raw_n = {irq_pin_n, port_pin_n};
  assign sense = sense_e'(level_opt);

  irq_pin_sync #(.W(NSRC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(raw_n), .sync_n(sync_n));

  irq_edge_detect #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur_n(sync_n), .fall(fall), .any_fall(any_fall));

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(any_fall),
    .clr_vec_i(vec_fetch), .clr_ack_i(ack_wr), .q(latch_status));

  always_comb begin
    level_low   = (sense == SENSE_EDGE_LEVEL) && !sync_n[IRQ_IDX];
    irq_pending = latch_status | level_low;
    gate_open   = !cpu_i_mask && irq_enable;
    irq_req     = irq_pending && gate_open;
    irq_take    = inst_boundary && irq_req;
    cpu_int_req = irq_req || swi_req;
  end

  p_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_opt && irq_pending) |-> latch_status);
  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (inst_boundary && irq_pending));
  p_swi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req |-> cpu_int_req);
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_i_mask |-> !irq_take);
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_pin_n = 1'b1;
  logic [3:0] port_pin_n = 4'hF;
  logic level_opt = 1'b0, cpu_i_mask = 1'b0, irq_enable = 1'b1;
  logic inst_boundary = 1'b0, vec_fetch = 1'b0, ack_wr = 1'b0, swi_req = 1'b0;
  logic latch_status, irq_pending, irq_req, irq_take, cpu_int_req;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin_n(port_pin_n),
    .level_opt(level_opt), .cpu_i_mask(cpu_i_mask), .irq_enable(irq_enable),
    .inst_boundary(inst_boundary), .vec_fetch(vec_fetch), .ack_wr(ack_wr),
    .swi_req(swi_req), .latch_status(latch_status), .irq_pending(irq_pending),
    .irq_req(irq_req), .irq_take(irq_take), .cpu_int_req(cpu_int_req));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_latch();
    ack_wr = 1'b1; step(1); ack_wr = 1'b0;
  endtask

  initial begin
    #4000000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(2); rst_n = 1'b1; step(1);
    chk("R1 reset", latch_status, 1'b0);
    chk("R1 reset req", cpu_int_req, 1'b0);

    // R1: dedicated pin, three-edge delay
    irq_pin_n = 1'b0; step(2);
    chk("R1 early", latch_status, 1'b0);
    step(1);
    chk("R1 set", latch_status, 1'b1);
    clear_latch();
    // R3: steady low then rising edge does nothing
    step(3); chk("R3 steady low", latch_status, 1'b0);
    irq_pin_n = 1'b1; step(4);
    chk("R3 rising", latch_status, 1'b0);

    // R2: each port pin, R3 rising edges ignored
    for (int b = 0; b < 4; b++) begin
      port_pin_n[b] = 1'b0; step(2);
      chk("R2 early", latch_status, 1'b0);
      step(1);
      chk("R2 port set", latch_status, 1'b1);
      clear_latch();
      chk("R8 ack clear", latch_status, 1'b0);
      port_pin_n[b] = 1'b1; step(4);
      chk("R3 port rising", latch_status, 1'b0);
    end

    // R4/R5 sweep over gates and boundary
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int bd = 0; bd < 2; bd++) begin
          cpu_i_mask = m[0]; irq_enable = e[0]; inst_boundary = bd[0];
          irq_pin_n = 1'b0; step(3);
          chk("R4 gated req", irq_req, (m == 0) && (e == 1));
          chk("R5 take", irq_take, (m == 0) && (e == 1) && (bd == 1));
          irq_pin_n = 1'b1; clear_latch(); step(3);
          chk("R4 idle req", irq_req, 1'b0);
        end
      end
    end
    inst_boundary = 1'b0; cpu_i_mask = 1'b0; irq_enable = 1'b1;

    // R6: vec fetch clear, new edge held under mask, taken on unmask
    port_pin_n[0] = 1'b0; step(3);
    cpu_i_mask = 1'b1; vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R6 vec clear", latch_status, 1'b0);
    port_pin_n[0] = 1'b1; step(1);
    port_pin_n[1] = 1'b0; step(3);
    chk("R6 held", latch_status, 1'b1);
    chk("R6 masked", irq_req, 1'b0);
    cpu_i_mask = 1'b0; #1;
    chk("R6 unmask req", irq_req, 1'b1);
    step(1); port_pin_n[1] = 1'b1; clear_latch(); step(3);

    // R7: set and clear in the same cycle
    irq_pin_n = 1'b0; step(3); irq_pin_n = 1'b1; step(3);
    chk("R7 pre", latch_status, 1'b1);
    port_pin_n[2] = 1'b0; step(2);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R7 vec set wins", latch_status, 1'b1);
    port_pin_n[2] = 1'b1; step(3);
    port_pin_n[3] = 1'b0; step(2);
    ack_wr = 1'b1; step(1); ack_wr = 1'b0;
    chk("R7 ack set wins", latch_status, 1'b1);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R7 lone clear", latch_status, 1'b0);
    port_pin_n[3] = 1'b1; step(3);

    // R9: level sensitivity
    level_opt = 1'b1;
    irq_pin_n = 1'b0; step(3);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R9 latch cleared", latch_status, 1'b0);
    chk("R9 level pending", irq_pending, 1'b1);
    chk("R9 level req", irq_req, 1'b1);
    irq_pin_n = 1'b1; step(3);
    chk("R9 released", irq_pending, 1'b0);
    port_pin_n[0] = 1'b0; step(3); clear_latch(); step(2);
    chk("R9 port not level", irq_pending, 1'b0);
    port_pin_n[0] = 1'b1; step(3); level_opt = 1'b0;

    // R10: software interrupt ignores gates
    for (int g = 0; g < 4; g++) begin
      cpu_i_mask = g[0]; irq_enable = g[1]; swi_req = 1'b1; #1;
      chk("R10 swi", cpu_int_req, 1'b1);
      swi_req = 1'b0; #1;
      chk("R10 swi off", cpu_int_req, 1'b0);
      step(1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule